// File: doc/BRIEF.md
# Compressor-Tree Unsigned Array Multiplier

This block multiplies two unsigned N-bit operands and returns the full 2N-bit product. The default is 8x8 with a 16-bit result. Partial products are laid out in the vertical-and-crosswise way: every bit a[i]&b[j] lands in output column i+j. This gives N shifted rows over 2N columns.

The rows are then reduced in layers. A layer takes up to seven rows and turns them into two, using one 7:2 cell per column. Each 7:2 cell is built from two multiplexer-based 4:2 cells and one full adder. Rows left over from a layer pass on to the next one unchanged. The layers repeat until two rows remain, and a carry-propagate adder sums those two rows into the product.

An optional output register (OUT_REG=1, the default) captures the product on a clock edge when `in_valid` is high. It raises `out_valid` for the following cycle. A synchronous reset clears the register and the strobe. With OUT_REG=0 the product and strobe follow the inputs combinationally.

Top module: `cvm_mult`

## Requirements
- R1: `product` equals the unsigned product a*b, written as 2N bits, for every pair of operands.
- R2: In the 4:2 cell (inputs x[0..3] taken as X1..X4, plus cin), `sum` equals the XOR of the five inputs.
- R3: In the 4:2 cell, `cout` equals X3 when X1 XOR X2 is 1 and equals X1 otherwise, so `cout` never depends on cin.
- R4: In the 4:2 cell, `carry` equals cin when X1^X2^X3^X4 is 1 and equals X4 otherwise. The count of ones among X1..X4 and cin equals sum + 2*(carry+cout).
- R5: In the 7:2 cell (inputs x[0..6], cin1, cin2), the count of ones over all nine inputs equals sum + 2*carry + 2*cout1 + 4*cout2. `cout1` depends only on x[0..3]. Inside a layer, cout1 of column k drives cin1 of column k+1, and cout2 of column k drives cin2 of column k+2.
- R6: With the output register present, `out_valid` in a cycle equals `in_valid` sampled at the previous rising edge. The product of the operands captured at that edge is shown in the same cycle.
- R7: An edge with `in_valid` low leaves `product` unchanged.
- R8: A synchronous reset (`rst` high at an edge) sets `product` to 0 and `out_valid` to 0.
- R9: No carry leaves the most significant column in any layer. Dropping such carries therefore loses nothing, and the all-ones operands give (2^N-1)^2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands are valid; loads the output register |
| a | input | N | Multiplicand, unsigned |
| b | input | N | Multiplier, unsigned |
| out_valid | output | 1 | Product register holds a new result |
| product | output | 2N | Unsigned product a*b |

## Verification
Every one of the 65,536 operand pairs of the default width is streamed back to back, one pair per cycle. This exposes any wrong column wiring, a broken carry link between 7:2 cells, or a bad leftover-row pass-through, because each of these corrupts specific pairs. The 4:2 cell is driven through all 32 input patterns and the 7:2 cell through all 512, separately from the tree. This tells a faulty multiplexer select apart from a wiring fault in the tree, and shows that cout and cout1 ignore their carry inputs. Directed cases cover zero operands, all-ones operands (the top-column carry boundary), holding the result while `in_valid` is low, and a reset in the middle of a run.

// File: rtl/cvm_pkg.sv
package cvm_pkg;

  // Rows left after one 7:2 layer acting on r rows.
  function automatic int rows_after(int r);
    if (r <= 2) return r;
    if (r < 7) return 2;
    return 2 * (r / 7) + (r % 7);
  endfunction

  // Rows entering layer lvl when the tree starts with n rows.
  function automatic int rows_at(int n, int lvl);
    int r;
    r = n;
    for (int i = 0; i < lvl; i++) r = rows_after(r);
    return r;
  endfunction

  // Number of layers needed to reach two rows.
  function automatic int level_count(int n);
    int r;
    int c;
    r = n;
    c = 0;
    while (r > 2) begin
      r = rows_after(r);
      c++;
    end
    return c;
  endfunction

  function automatic logic fa_sum(logic x, logic y, logic z);
    return x ^ y ^ z;
  endfunction

  function automatic logic fa_cy(logic x, logic y, logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction

endpackage

// File: rtl/cvm_c42.sv
module cvm_c42 (
  input  logic [3:0] x,
  input  logic       cin,
  output logic       sum,
  output logic       carry,
  output logic       cout
);
  // early select terms
  logic sel_pair;
  logic sel_quad;

  assign sel_pair = x[0] ^ x[1];
  assign sel_quad = sel_pair ^ x[2] ^ x[3];

  assign cout  = sel_pair ? x[2] : x[0];
  assign carry = sel_quad ? cin  : x[3];
  assign sum   = sel_quad ? ~cin : cin;

  always_comb begin
    // R4
    c42_balance_chk: assert ($countones({x, cin}) ==
                             int'(sum) + 2 * (int'(carry) + int'(cout)))
      else $error("4:2 cell count mismatch");
  end
endmodule

// File: rtl/cvm_c72.sv
module cvm_c72
  import cvm_pkg::*;
(
  input  logic [6:0] x,
  input  logic       cin1,
  input  logic       cin2,
  output logic       sum,
  output logic       carry,
  output logic       cout1,
  output logic       cout2
);
  logic s_lo;
  logic cy_lo;
  logic cy_hi;
  logic co_hi;

  cvm_c42 u_lo (
    .x(x[3:0]), .cin(cin1), .sum(s_lo), .carry(cy_lo), .cout(cout1)
  );

  cvm_c42 u_hi (
    .x({s_lo, x[6:4]}), .cin(cin2), .sum(sum), .carry(cy_hi), .cout(co_hi)
  );

  assign carry = fa_sum(cy_lo, cy_hi, co_hi);
  assign cout2 = fa_cy(cy_lo, cy_hi, co_hi);

  always_comb begin
    // R5
    c72_balance_chk: assert ($countones({x, cin1, cin2}) ==
                             int'(sum) + 2 * int'(carry) + 2 * int'(cout1) + 4 * int'(cout2))
      else $error("7:2 cell count mismatch");
  end
endmodule

// File: rtl/cvm_row72.sv
module cvm_row72 #(
  parameter int W = 16
) (
  input  logic [6:0][W-1:0] rows_i,
  output logic [W-1:0]      sum_o,
  output logic [W-1:0]      carry_o,
  output logic              drop_o
);
  logic [W-1:0] cy;

  for (genvar k = 0; k < W; k++) begin : g_col
    logic [6:0] bits;
    logic       c1_in;
    logic       c2_in;
    logic       co1;
    logic       co2;

    for (genvar r = 0; r < 7; r++) begin : g_bit
      assign bits[r] = rows_i[r][k];
    end

    // R5: cout1 to the next column, cout2 two columns up
    if (k == 0) begin : g_c1_zero
      assign c1_in = 1'b0;
    end else begin : g_c1_link
      assign c1_in = g_col[k-1].co1;
    end

    if (k < 2) begin : g_c2_zero
      assign c2_in = 1'b0;
    end else begin : g_c2_link
      assign c2_in = g_col[k-2].co2;
    end

    cvm_c72 u_cell (
      .x(bits), .cin1(c1_in), .cin2(c2_in),
      .sum(sum_o[k]), .carry(cy[k]), .cout1(co1), .cout2(co2)
    );
  end

  assign carry_o = {cy[W-2:0], 1'b0};
  // R9: anything leaving the top column is flagged
  assign drop_o  = cy[W-1] | g_col[W-1].co1 | g_col[W-1].co2 | g_col[W-2].co2;
endmodule

// File: rtl/cvm_ppgen.sv
module cvm_ppgen #(
  parameter int N  = 8,
  parameter int W2 = 2 * N
) (
  input  logic [N-1:0]      a,
  input  logic [N-1:0]      b,
  output logic [N*W2-1:0]   rows_o
);
  // row j carries a[i]&b[j] at column i+j
  for (genvar j = 0; j < N; j++) begin : g_row
    for (genvar k = 0; k < W2; k++) begin : g_colbit
      if (k >= j && k - j < N) begin : g_term
        assign rows_o[j*W2 + k] = a[k-j] & b[j];
      end else begin : g_pad
        assign rows_o[j*W2 + k] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/cvm_tree.sv
module cvm_tree
  import cvm_pkg::*;
#(
  parameter int N  = 8,
  parameter int W2 = 2 * N
) (
  input  logic [N*W2-1:0] pp_i,
  output logic [W2-1:0]   row_s_o,
  output logic [W2-1:0]   row_c_o,
  output logic            drop_o
);
  localparam int NL = level_count(N);

  logic [NL:0] drop_l;
  assign drop_l[NL] = 1'b0;

  for (genvar l = 0; l < NL; l++) begin : g_lvl
    localparam int RIN  = rows_at(N, l);
    localparam int ROUT = rows_after(RIN);
    localparam int NG   = (RIN < 7) ? 1 : RIN / 7;
    localparam int LEFT = (RIN < 7) ? 0 : RIN % 7;

    logic [RIN*W2-1:0]  rows_i;
    logic [ROUT*W2-1:0] rows_o;
    logic [NG-1:0]      drop_g;

    if (l == 0) begin : g_src
      assign rows_i = pp_i;
    end else begin : g_chain
      assign rows_i = g_lvl[l-1].rows_o;
    end

    for (genvar g = 0; g < NG; g++) begin : g_grp
      logic [6:0][W2-1:0] gin;
      for (genvar r = 0; r < 7; r++) begin : g_in
        if (7 * g + r < RIN) begin : g_use
          assign gin[r] = rows_i[(7*g+r)*W2 +: W2];
        end else begin : g_zero
          assign gin[r] = '0;
        end
      end
      cvm_row72 #(.W(W2)) u_row (
        .rows_i (gin),
        .sum_o  (rows_o[(2*g)*W2 +: W2]),
        .carry_o(rows_o[(2*g+1)*W2 +: W2]),
        .drop_o (drop_g[g])
      );
    end

    for (genvar r = 0; r < LEFT; r++) begin : g_pass
      assign rows_o[(2*NG+r)*W2 +: W2] = rows_i[(7*NG+r)*W2 +: W2];
    end

    assign drop_l[l] = |drop_g;
  end

  if (NL == 0) begin : g_direct
    assign row_s_o = pp_i[W2-1:0];
    assign row_c_o = pp_i[2*W2-1:W2];
  end else begin : g_final
    assign row_s_o = g_lvl[NL-1].rows_o[W2-1:0];
    assign row_c_o = g_lvl[NL-1].rows_o[2*W2-1:W2];
  end

  assign drop_o = |drop_l;
endmodule

// File: rtl/cvm_mult.sv
module cvm_mult #(
  parameter int N       = 8,
  parameter bit OUT_REG = 1'b1,
  localparam int W2     = 2 * N
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [N-1:0]  a,
  input  logic [N-1:0]  b,
  output logic          out_valid,
  output logic [W2-1:0] product
);
  logic [N*W2-1:0] pp_rows;
  logic [W2-1:0]   row_s;
  logic [W2-1:0]   row_c;
  logic [W2-1:0]   prod_c;
  logic            drop_any;

  cvm_ppgen #(.N(N), .W2(W2)) u_pp (.a(a), .b(b), .rows_o(pp_rows));

  cvm_tree #(.N(N), .W2(W2)) u_tree (
    .pp_i(pp_rows), .row_s_o(row_s), .row_c_o(row_c), .drop_o(drop_any)
  );

  // final carry-propagate add; top carry discarded (see R9)
  assign prod_c = row_s + row_c;

  // R9
  no_drop_chk: assert property (@(posedge clk) disable iff (rst) !drop_any)
    else $error("carry left the top column");

  if (OUT_REG) begin : g_reg
    logic [W2-1:0] prod_q;
    logic          vld_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        prod_q <= '0;
        vld_q  <= 1'b0;
      end else begin
        vld_q <= in_valid;
        if (in_valid) prod_q <= prod_c;
      end
    end

    assign product   = prod_q;
    assign out_valid = vld_q;

    // R6
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> out_valid == $past(in_valid))
      else $error("out_valid does not follow in_valid");

    // R1
    product_value_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(in_valid)) |->
        product == W2'($past(a)) * W2'($past(b)))
      else $error("product differs from a*b");

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(in_valid)) |-> $stable(product))
      else $error("product moved without in_valid");

    // R8
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!out_valid && product == '0))
      else $error("reset did not clear outputs");
  end else begin : g_comb
    assign product   = prod_c;
    assign out_valid = in_valid;
  end
endmodule

// File: tb/tb_cvm_mult.sv
module tb_cvm_mult;
  localparam int N  = 8;
  localparam int W2 = 2 * N;
  localparam time CLK_P = 8ns;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [N-1:0]  a = '0;
  logic [N-1:0]  b = '0;
  logic          out_valid;
  logic [W2-1:0] product;

  logic [3:0] c4_x = '0;
  logic       c4_cin = 1'b0;
  logic       c4_sum, c4_carry, c4_cout;
  logic [6:0] c7_x = '0;
  logic       c7_cin1 = 1'b0, c7_cin2 = 1'b0;
  logic       c7_sum, c7_carry, c7_cout1, c7_cout2;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  cvm_mult #(.N(N), .OUT_REG(1'b1)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .a(a), .b(b),
    .out_valid(out_valid), .product(product)
  );

  cvm_c42 u_c42 (.x(c4_x), .cin(c4_cin), .sum(c4_sum), .carry(c4_carry), .cout(c4_cout));
  cvm_c72 u_c72 (.x(c7_x), .cin1(c7_cin1), .cin2(c7_cin2), .sum(c7_sum),
                 .carry(c7_carry), .cout1(c7_cout1), .cout2(c7_cout2));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic t_reset_state();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(out_valid === 1'b0, "R8 out_valid after reset", 32'(out_valid), 0);
    check(product === '0, "R8 product after reset", 32'(product), 0);
  endtask

  // R2 R3 R4: all 32 patterns of the 4:2 cell
  task automatic t_cell42();
    for (int p = 0; p < 32; p++) begin
      logic x1, x2, x3, x4, ci, e_sum, e_cout, e_carry;
      c4_x = p[3:0];
      c4_cin = p[4];
      #1;
      {x4, x3, x2, x1} = p[3:0];
      ci = p[4];
      e_sum   = x1 ^ x2 ^ x3 ^ x4 ^ ci;
      e_cout  = (x1 != x2) ? x3 : x1;
      e_carry = ((x1 + x2 + x3 + x4) % 2 == 1) ? ci : x4;
      check(c4_sum === e_sum, "R2 4:2 sum", 32'(c4_sum), 32'(e_sum));
      check(c4_cout === e_cout, "R3 4:2 cout", 32'(c4_cout), 32'(e_cout));
      check(c4_carry === e_carry, "R4 4:2 carry", 32'(c4_carry), 32'(e_carry));
      check(int'(x1) + x2 + x3 + x4 + ci == int'(c4_sum) + 2 * (int'(c4_carry) + int'(c4_cout)),
            "R4 4:2 count", 32'(int'(c4_sum) + 2 * (int'(c4_carry) + int'(c4_cout))),
            32'(int'(x1) + x2 + x3 + x4 + ci));
    end
  endtask

  // R5: all 512 patterns of the 7:2 cell
  task automatic t_cell72();
    for (int p = 0; p < 512; p++) begin
      int ones;
      int got;
      c7_x = p[6:0];
      c7_cin1 = p[7];
      c7_cin2 = p[8];
      #1;
      ones = $countones(p[8:0]);
      got  = int'(c7_sum) + 2 * int'(c7_carry) + 2 * int'(c7_cout1) + 4 * int'(c7_cout2);
      check(got == ones, "R5 7:2 count", 32'(got), 32'(ones));
    end
    for (int p = 0; p < 128; p++) begin
      logic ref_c1;
      c7_x = p[6:0];
      c7_cin1 = 1'b0;
      c7_cin2 = 1'b0;
      #1;
      ref_c1 = c7_cout1;
      for (int c = 1; c < 4; c++) begin
        c7_cin1 = c[0];
        c7_cin2 = c[1];
        #1;
        check(c7_cout1 === ref_c1, "R5 cout1 ignores carries", 32'(c7_cout1), 32'(ref_c1));
      end
      c7_x = {p[6:4], 4'b0000};
      c7_cin1 = 1'b0;
      c7_cin2 = 1'b0;
      #1;
      check(c7_cout1 === 1'b0, "R5 cout1 from x[0..3] only", 32'(c7_cout1), 0);
    end
  endtask

  // R1 R6: every operand pair, one per cycle
  task automatic t_all_pairs();
    logic [W2-1:0] want;
    bit have;
    want = '0;
    have = 1'b0;
    for (int i = 0; i < (1 << (2 * N)); i++) begin
      @(negedge clk);
      if (have) begin
        check(out_valid === 1'b1, "R6 out_valid", 32'(out_valid), 1);
        check(product === want, "R1 product", 32'(product), 32'(want));
      end
      a = N'(i);
      b = N'(i >> N);
      in_valid = 1'b1;
      want = W2'(a) * W2'(b);
      have = 1'b1;
    end
    @(negedge clk);
    check(product === want, "R1 last product", 32'(product), 32'(want));
    in_valid = 1'b0;
    @(negedge clk);
    check(out_valid === 1'b0, "R6 out_valid drops", 32'(out_valid), 0);
  endtask

  // R9 and R1 corners: all ones, zero
  task automatic t_corners();
    logic [W2-1:0] top;
    top = W2'({N{1'b1}}) * W2'({N{1'b1}});
    a = '1; b = '1; in_valid = 1'b1;
    @(negedge clk);
    check(product === top, "R9 all-ones product", 32'(product), 32'(top));
    a = '0; b = '1;
    @(negedge clk);
    check(product === '0, "R1 zero operand", 32'(product), 0);
    a = N'(1); b = '1;
    @(negedge clk);
    check(product === W2'({N{1'b1}}), "R1 unit operand", 32'(product), 32'({N{1'b1}}));
    in_valid = 1'b0;
  endtask

  // R7: result kept while in_valid is low
  task automatic t_hold();
    a = N'(13); b = N'(11); in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    a = N'(200); b = N'(250);
    @(negedge clk);
    check(product === W2'(143), "R7 hold 1", 32'(product), 143);
    check(out_valid === 1'b0, "R7 no strobe", 32'(out_valid), 0);
    @(negedge clk);
    check(product === W2'(143), "R7 hold 2", 32'(product), 143);
  endtask

  // R8: reset mid-run
  task automatic t_mid_reset();
    a = N'(77); b = N'(91); in_valid = 1'b1;
    @(negedge clk);
    check(product === W2'(7007), "R1 before reset", 32'(product), 7007);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    in_valid = 1'b0;
    check(product === '0, "R8 mid-run product", 32'(product), 0);
    check(out_valid === 1'b0, "R8 mid-run out_valid", 32'(out_valid), 0);
  endtask

  initial begin
    #(CLK_P * 190000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_cell42();
    t_cell72();
    t_all_pairs();
    t_corners();
    t_hold();
    t_mid_reset();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule